// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is a single DMA channel that moves words between a memory port and a device port. Software loads a pair of working pointers (next and limit) that describe the current buffer. It can also load a second pair (start and stop) that describes a follow-on buffer. The channel is then started through a command/status register. Each word advances the next pointer by one word. When next reaches limit, the channel either reloads the working pair from the follow-on pair and keeps going, or it halts. Completion and bus faults are reported through status bits and a level interrupt.

Control writes carry separate command bits for setting, clearing and resetting, so software never has to read, modify and write the register. Every chain reload updates four shadow pointer registers, and software can also fill them on demand. They hold what is needed to restart an interrupted transfer. In read direction, data flows from the device into memory. In write direction, data flows from memory to the device.

Top module: `dma_chain_ch`

## Requirements
- R1: After reset, the control/status word reads 0, all pointers read 0, `irq` is low and `mem_req` is low.
- R2: Register index map: 0 control/status, 1 next, 2 limit, 3 start, 4 stop, 5 saved next, 6 saved limit, 7 saved start, 8 saved stop. A pointer write stores the value with its low ALIGN_LSB bits cleared, which gives 16-byte alignment by default.
- R3: Status bit 26 selects the direction. When bit 26 is 1 (read), each word accepted from the device port is written to memory at next. When bit 26 is 0 (write), memory is read at next and the word is offered on the device port. In both directions next grows by DATA_W/8 bytes per finished word.
- R4: The current buffer ends when next equals limit. If single-update (status bit 25) is set, or no follow-on buffer is pending, the channel then sets complete (bit 27), clears enable (bit 24) and issues no further requests.
- R5: Command bit 19 clears complete. `irq` is high exactly while complete or bus-exception is set.
- R6: A write to the stop register marks a follow-on buffer as pending. At buffer end with single-update clear and a buffer pending, next takes start and limit takes stop. Complete is set, enable stays set, the transfer continues, and the pending mark is cleared.
- R7: On each chain reload, the saved next and saved start registers take the start value, and the saved limit and saved stop registers take the stop value. Command bit 21 copies the four working pointers into the four saved registers.
- R8: A memory acknowledge that arrives with `mem_err` high sets bus-exception (status bit 28), clears enable, and leaves next at the faulting address. While bus-exception is set, no memory request is issued, even if enable is set.
- R9: Command bit 20 clears enable, single-update, complete, bus-exception and the pending follow-on mark.
- R10: Command bit 16 sets enable and command bit 17 sets single-update; within one write, the reset command acts before these. Command bit 18 is loaded into the direction bit only by a control write made while enable is clear and no word is in flight.
- R11: Once raised, `mem_req` stays high with unchanged `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Bus error, sampled with mem_ack |
| dev_in_valid | input | 1 | Device word available |
| dev_in_ready | output | 1 | Channel accepts device word |
| dev_in_data | input | DATA_W | Device word into the channel |
| dev_out_valid | output | 1 | Channel offers word to device |
| dev_out_ready | input | 1 | Device accepts offered word |
| dev_out_data | output | DATA_W | Word to the device |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with ADDR_W=16, DATA_W=32 and ALIGN_LSB=4. With these values a 16-byte buffer is four words, so buffer ends, chain reloads and halts come within a few dozen cycles. The 16-bit addresses also let the memory model return an address-derived word that the scoreboard can predict. Memory wait states and a device sink that stalls every third cycle exercise the request-hold rule and the chain boundary under backpressure.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;

  localparam int REG_W = 32;

  // status bit positions (read view of the control word)
  localparam int ST_EN   = 24;
  localparam int ST_SUP  = 25;
  localparam int ST_RD   = 26;
  localparam int ST_DONE = 27;
  localparam int ST_BERR = 28;

  // command field lives at bits 21..16 of a control write
  localparam int CMD_LSB = 16;
  localparam int CMD_MSB = 21;

  typedef struct packed {
    logic snap;      // bit 21
    logic rst;       // bit 20
    logic clr_done;  // bit 19
    logic dir_rd;    // bit 18
    logic set_sup;   // bit 17
    logic set_en;    // bit 16
  } cmd_t;

  typedef enum logic [3:0] {
    IDX_CSR      = 4'd0,
    IDX_NEXT     = 4'd1,
    IDX_LIMIT    = 4'd2,
    IDX_START    = 4'd3,
    IDX_STOP     = 4'd4,
    IDX_SV_NEXT  = 4'd5,
    IDX_SV_LIMIT = 4'd6,
    IDX_SV_START = 4'd7,
    IDX_SV_STOP  = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_DEV_IN,
    MV_MEM,
    MV_DEV_OUT
  } mv_state_e;

  // clear the low 'lsb' bits of a pointer
  function automatic logic [REG_W-1:0] align_down(input logic [REG_W-1:0] p,
                                                  input int unsigned lsb);
    return p & ~((REG_W'(1) << lsb) - REG_W'(1));
  endfunction

  // advance a pointer by one word
  function automatic logic [REG_W-1:0] word_step(input logic [REG_W-1:0] p,
                                                 input int unsigned bytes);
    return p + REG_W'(bytes);
  endfunction

endpackage

// File: rtl/dma_cmd_status.sv
`timescale 1ns/1ps
module dma_cmd_status
  import dma_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  cmd_t cmd,
  input  logic mv_busy,
  input  logic buf_end,
  input  logic chain_take,
  input  logic bus_err,
  output logic en,
  output logic sup,
  output logic dir_rd,
  output logic done,
  output logic berr
);

  logic hw_halt;
  logic sw_reset;
  logic dir_open;

  assign hw_halt  = bus_err | (buf_end & ~chain_take);
  assign sw_reset = cmd_we & cmd.rst;
  assign dir_open = cmd_we & ~en & ~mv_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      sup    <= 1'b0;
      dir_rd <= 1'b0;
      done   <= 1'b0;
      berr   <= 1'b0;
    end else begin
      // enable: hardware halt wins, then set, then reset command
      if (hw_halt)                en <= 1'b0;
      else if (cmd_we & cmd.set_en) en <= 1'b1;
      else if (sw_reset)          en <= 1'b0;

      if (cmd_we & cmd.set_sup)   sup <= 1'b1;
      else if (sw_reset)          sup <= 1'b0;

      // hardware completion wins over a clear in the same cycle
      if (buf_end)                             done <= 1'b1;
      else if (cmd_we & (cmd.rst | cmd.clr_done)) done <= 1'b0;

      if (bus_err)                berr <= 1'b1;
      else if (sw_reset)          berr <= 1'b0;

      if (dir_open)               dir_rd <= cmd.dir_rd;
    end
  end

  // R8: bus exception persists until a reset command
  a_r8_berr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    berr && !sw_reset |=> berr);

  // R4: an unchained buffer end halts the channel with complete raised
  a_r4_halt_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end && !chain_take |=> !en && done);

  // R10: direction cannot move while the channel is enabled
  a_r10_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(dir_rd));

endmodule

// File: rtl/dma_ptr_bank.sv
`timescale 1ns/1ps
module dma_ptr_bank
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_LSB  = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_idx_e          wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              snap,
  input  logic              chain_clr,
  input  logic              word_done,
  input  logic              supdate,
  output logic [ADDR_W-1:0] p_next,
  output logic [ADDR_W-1:0] p_limit,
  output logic [ADDR_W-1:0] p_start,
  output logic [ADDR_W-1:0] p_stop,
  output logic [ADDR_W-1:0] sv_next,
  output logic [ADDR_W-1:0] sv_limit,
  output logic [ADDR_W-1:0] sv_start,
  output logic [ADDR_W-1:0] sv_stop,
  output logic              buf_end,
  output logic              chain_take
);

  logic [REG_W-1:0]  wr_aligned;
  logic [REG_W-1:0]  next_inc;
  logic [ADDR_W-1:0] next_adv;
  logic [ADDR_W-1:0] wr_ptr;
  logic              chain_pend;

  assign wr_aligned = align_down(wr_data, ALIGN_LSB);
  assign wr_ptr     = wr_aligned[ADDR_W-1:0];
  assign next_inc   = word_step(REG_W'(p_next), WORD_BYTES);
  assign next_adv   = next_inc[ADDR_W-1:0];

  assign buf_end    = word_done & (next_adv == p_limit);
  assign chain_take = buf_end & ~supdate & chain_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_next     <= '0;
      p_limit    <= '0;
      p_start    <= '0;
      p_stop     <= '0;
      chain_pend <= 1'b0;
    end else begin
      if (chain_take)                          p_next <= p_start;
      else if (word_done)                      p_next <= next_adv;
      else if (wr_en && wr_idx == IDX_NEXT)    p_next <= wr_ptr;

      if (chain_take)                          p_limit <= p_stop;
      else if (wr_en && wr_idx == IDX_LIMIT)   p_limit <= wr_ptr;

      if (wr_en && wr_idx == IDX_START)        p_start <= wr_ptr;
      if (wr_en && wr_idx == IDX_STOP)         p_stop  <= wr_ptr;

      if (wr_en && wr_idx == IDX_STOP)         chain_pend <= 1'b1;
      else if (chain_take || chain_clr)        chain_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_next  <= '0;
      sv_limit <= '0;
      sv_start <= '0;
      sv_stop  <= '0;
    end else if (chain_take) begin
      sv_next  <= p_start;
      sv_limit <= p_stop;
      sv_start <= p_start;
      sv_stop  <= p_stop;
    end else if (snap) begin
      sv_next  <= p_next;
      sv_limit <= p_limit;
      sv_start <= p_start;
      sv_stop  <= p_stop;
    end
  end

  // R6: a chain reload moves the follow-on pair into the working pair
  a_r6_chain_reload: assert property (@(posedge clk) disable iff (!rst_n)
    chain_take |=> p_next == $past(p_start) && p_limit == $past(p_stop));

  // R7: shadows follow the reload
  a_r7_shadow_reload: assert property (@(posedge clk) disable iff (!rst_n)
    chain_take |=> sv_next == p_next && sv_limit == p_limit);

  generate
    if (ALIGN_LSB > 0) begin : g_align_chk
      // R2: a software-written next pointer is aligned
      a_r2_next_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_idx == IDX_NEXT && !word_done && !chain_take
        |=> p_next[ALIGN_LSB-1:0] == '0);
    end
  endgenerate

endmodule

// File: rtl/dma_word_mover.sv
`timescale 1ns/1ps
module dma_word_mover
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              dir_rd,
  input  logic [ADDR_W-1:0] next_ptr,
  input  logic [ADDR_W-1:0] limit_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              word_done,
  output logic              bus_err,
  output logic              busy
);

  mv_state_e         st;
  logic [DATA_W-1:0] hold;
  logic [ADDR_W-1:0] cur_addr;
  logic              launch;
  logic              mem_fin;

  assign launch  = run_ok & (next_ptr != limit_ptr);
  assign mem_fin = (st == MV_MEM) & mem_ack;

  assign mem_req       = (st == MV_MEM);
  assign mem_we        = dir_rd;
  assign mem_addr      = cur_addr;
  assign mem_wdata     = hold;
  assign dev_in_ready  = (st == MV_DEV_IN);
  assign dev_out_valid = (st == MV_DEV_OUT);
  assign dev_out_data  = hold;

  assign bus_err   = mem_fin & mem_err;
  assign word_done = (mem_fin & ~mem_err & dir_rd) |
                     ((st == MV_DEV_OUT) & dev_out_ready);
  assign busy      = (st != MV_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= MV_IDLE;
      hold     <= '0;
      cur_addr <= '0;
    end else begin
      unique case (st)
        MV_IDLE: begin
          if (launch) begin
            cur_addr <= next_ptr;
            st       <= dir_rd ? MV_DEV_IN : MV_MEM;
          end
        end
        MV_DEV_IN: begin
          if (!run_ok) begin
            st <= MV_IDLE;
          end else if (dev_in_valid) begin
            hold <= dev_in_data;
            st   <= MV_MEM;
          end
        end
        MV_MEM: begin
          if (mem_ack) begin
            if (mem_err || dir_rd) begin
              st <= MV_IDLE;
            end else begin
              hold <= mem_rdata;
              st   <= MV_DEV_OUT;
            end
          end
        end
        MV_DEV_OUT: begin
          if (dev_out_ready) st <= MV_IDLE;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  // R11: an unanswered request keeps its address, data and kind
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) &&
                            $stable(mem_wdata) && $stable(mem_we));

  // R8: a faulted access is not retried on the next cycle
  a_r8_err_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !mem_req);

endmodule

// File: rtl/dma_chain_ch.sv
`timescale 1ns/1ps
module dma_chain_ch
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ALIGN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data,
  output logic              irq
);

  localparam int WORD_BYTES = DATA_W / 8;

  reg_idx_e          reg_idx;
  cmd_t              cmd;
  logic              cmd_we;
  logic              en, sup, dir_rd, done, berr;
  logic              mv_busy, word_done, bus_err;
  logic              buf_end, chain_take;
  logic [ADDR_W-1:0] p_next, p_limit, p_start, p_stop;
  logic [ADDR_W-1:0] sv_next, sv_limit, sv_start, sv_stop;
  logic [REG_W-1:0]  csr_word;

  assign reg_idx = reg_idx_e'(reg_addr);
  assign cmd     = cmd_t'(reg_wdata[CMD_MSB:CMD_LSB]);
  assign cmd_we  = reg_we & (reg_idx == IDX_CSR);

  dma_cmd_status u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd        (cmd),
    .mv_busy    (mv_busy),
    .buf_end    (buf_end),
    .chain_take (chain_take),
    .bus_err    (bus_err),
    .en         (en),
    .sup        (sup),
    .dir_rd     (dir_rd),
    .done       (done),
    .berr       (berr)
  );

  dma_ptr_bank #(
    .ADDR_W     (ADDR_W),
    .ALIGN_LSB  (ALIGN_LSB),
    .WORD_BYTES (WORD_BYTES)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .wr_idx     (reg_idx),
    .wr_data    (reg_wdata),
    .snap       (cmd_we & cmd.snap),
    .chain_clr  (cmd_we & cmd.rst),
    .word_done  (word_done),
    .supdate    (sup),
    .p_next     (p_next),
    .p_limit    (p_limit),
    .p_start    (p_start),
    .p_stop     (p_stop),
    .sv_next    (sv_next),
    .sv_limit   (sv_limit),
    .sv_start   (sv_start),
    .sv_stop    (sv_stop),
    .buf_end    (buf_end),
    .chain_take (chain_take)
  );

  dma_word_mover #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mover (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_ok        (en & ~berr),
    .dir_rd        (dir_rd),
    .next_ptr      (p_next),
    .limit_ptr     (p_limit),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .mem_ack       (mem_ack),
    .mem_err       (mem_err),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_in_data   (dev_in_data),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .word_done     (word_done),
    .bus_err       (bus_err),
    .busy          (mv_busy)
  );

  always_comb begin
    csr_word          = '0;
    csr_word[ST_EN]   = en;
    csr_word[ST_SUP]  = sup;
    csr_word[ST_RD]   = dir_rd;
    csr_word[ST_DONE] = done;
    csr_word[ST_BERR] = berr;
  end

  always_comb begin
    unique case (reg_idx)
      IDX_CSR:      reg_rdata = csr_word;
      IDX_NEXT:     reg_rdata = REG_W'(p_next);
      IDX_LIMIT:    reg_rdata = REG_W'(p_limit);
      IDX_START:    reg_rdata = REG_W'(p_start);
      IDX_STOP:     reg_rdata = REG_W'(p_stop);
      IDX_SV_NEXT:  reg_rdata = REG_W'(sv_next);
      IDX_SV_LIMIT: reg_rdata = REG_W'(sv_limit);
      IDX_SV_START: reg_rdata = REG_W'(sv_start);
      IDX_SV_STOP:  reg_rdata = REG_W'(sv_stop);
      default:      reg_rdata = '0;
    endcase
  end

  assign irq = done | berr;

  // R8: the status-side fault bit blocks the mover's request path
  a_r8_no_req_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> !mem_req);

  // R3: a finished word outside a chain reload advances next by one word
  a_r3_word_advance: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !chain_take |=> p_next != $past(p_next));

endmodule

// File: tb/dma_chain_ch_test.sv
`timescale 1ns/1ps
module dma_chain_ch_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int AL = 4;

  localparam logic [31:0] C_SET_EN  = 32'h0001_0000;
  localparam logic [31:0] C_SET_SUP = 32'h0002_0000;
  localparam logic [31:0] C_DIR_RD  = 32'h0004_0000;
  localparam logic [31:0] C_CLR_DN  = 32'h0008_0000;
  localparam logic [31:0] C_RESET   = 32'h0010_0000;
  localparam logic [31:0] C_SNAP    = 32'h0020_0000;
  localparam logic [31:0] S_EN   = 32'h0100_0000;
  localparam logic [31:0] S_SUP  = 32'h0200_0000;
  localparam logic [31:0] S_RD   = 32'h0400_0000;
  localparam logic [31:0] S_DONE = 32'h0800_0000;
  localparam logic [31:0] S_BERR = 32'h1000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, reg_we;
  logic [3:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          mem_req, mem_we, mem_ack, mem_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready;
  logic [DW-1:0] dev_in_data, dev_out_data;
  logic          irq;

  dma_chain_ch #(.ADDR_W(AW), .DATA_W(DW), .ALIGN_LSB(AL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data), .irq(irq));

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] exp_maddr[$];
  logic [DW-1:0] exp_mdata[$];
  logic [DW-1:0] exp_dev[$];
  logic [DW-1:0] exp_seq;
  logic [DW-1:0] src_seq;
  logic [AW-1:0] err_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {16'hC0DE, a};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    @(negedge clk);
    reg_addr = idx;
    #1 v = reg_rdata;
  endtask

  task automatic wait_halt();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd0, v);
      if (!v[24]) break;
    end
  endtask

  // driver side of the scoreboard: expected memory writes (read direction)
  task automatic push_rd(input logic [AW-1:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      exp_maddr.push_back(base + AW'(4 * i));
      exp_mdata.push_back(exp_seq);
      exp_seq++;
    end
  endtask

  // expected device words (write direction)
  task automatic push_wr(input logic [AW-1:0] base, input int n);
    for (int i = 0; i < n; i++) exp_dev.push_back(memf(base + AW'(4 * i)));
  endtask

  // memory model: one wait state, checks R11 hold, compares writes
  initial begin
    logic          seen;
    logic [AW-1:0] h_a;
    logic [DW-1:0] h_d;
    seen = 1'b0; h_a = '0; h_d = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (seen) begin
          chk("R11 addr held", 32'(mem_addr), 32'(h_a));
          chk("R11 data held", mem_wdata, h_d);
          mem_ack   = 1'b1;
          mem_rdata = memf(mem_addr);
          mem_err   = (mem_addr == err_addr);
          if (!mem_err && mem_we) begin
            if (exp_maddr.size() == 0) begin
              chk("R3 unexpected mem write", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
              chk("R3 mem write addr", 32'(mem_addr), 32'(exp_maddr.pop_front()));
              chk("R3 mem write data", mem_wdata, exp_mdata.pop_front());
            end
          end
          seen = 1'b0;
        end else begin
          seen = 1'b1; h_a = mem_addr; h_d = mem_wdata;
        end
      end else begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end
    end
  end

  // device source: always valid, counting data
  initial begin
    logic taken;
    taken = 1'b0;
    src_seq = 32'h1000_0000;
    dev_in_valid = 1'b1;
    dev_in_data = src_seq;
    forever begin
      @(negedge clk);
      if (taken) src_seq++;
      dev_in_data = src_seq;
      taken = dev_in_ready;
    end
  end

  // device sink monitor: stalls every third cycle
  initial begin
    int cnt;
    cnt = 0;
    dev_out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      dev_out_ready = (cnt % 3) != 0;
      if (dev_out_valid && dev_out_ready) begin
        if (exp_dev.size() == 0) chk("R3 unexpected dev word", dev_out_data, 32'hFFFF_FFFF);
        else chk("R3 dev word", dev_out_data, exp_dev.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int reqs;
    exp_seq = 32'h1000_0000;
    err_addr = 16'hFFFF;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); chk("R1 csr", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 mem_req", 32'(mem_req), 32'h0);
    rd(4'd1, v); chk("R1 next", v, 32'h0);
    rd(4'd8, v); chk("R1 saved stop", v, 32'h0);

    // R2 alignment of pointer writes
    wr(4'd1, 32'h0000_1237); rd(4'd1, v); chk("R2 next aligned", v, 32'h1230);
    wr(4'd2, 32'h0000_002F); rd(4'd2, v); chk("R2 limit aligned", v, 32'h0020);

    // R3/R4 read direction, no chain pending
    wr(4'd1, 32'h100); wr(4'd2, 32'h110);
    push_rd(16'h100, 4);
    wr(4'd0, C_SET_EN | C_DIR_RD);
    wait_halt();
    rd(4'd0, v); chk("R4 csr after end", v, S_RD | S_DONE);
    rd(4'd1, v); chk("R4 next at limit", v, 32'h110);
    chk("R5 irq on complete", 32'(irq), 32'h1);
    chk("R3 read queue drained", 32'(exp_maddr.size()), 32'h0);

    // R5 clear-complete
    wr(4'd0, C_CLR_DN);
    rd(4'd0, v); chk("R5 csr cleared", v, 32'h0);
    chk("R5 irq low", 32'(irq), 32'h0);

    // R6/R7 write direction with a chained second buffer
    wr(4'd1, 32'h200); wr(4'd2, 32'h210); wr(4'd3, 32'h300); wr(4'd4, 32'h320);
    push_wr(16'h200, 4); push_wr(16'h300, 8);
    wr(4'd0, C_SET_EN);
    wait_halt();
    rd(4'd0, v); chk("R6 csr after chain", v, S_DONE);
    rd(4'd1, v); chk("R6 next", v, 32'h320);
    rd(4'd2, v); chk("R6 limit", v, 32'h320);
    rd(4'd5, v); chk("R7 saved next", v, 32'h300);
    rd(4'd6, v); chk("R7 saved limit", v, 32'h320);
    rd(4'd7, v); chk("R7 saved start", v, 32'h300);
    rd(4'd8, v); chk("R7 saved stop", v, 32'h320);
    chk("R6 dev queue drained", 32'(exp_dev.size()), 32'h0);
    wr(4'd0, C_CLR_DN);

    // R4 single-update blocks a pending chain
    wr(4'd1, 32'h400); wr(4'd2, 32'h410); wr(4'd3, 32'h500); wr(4'd4, 32'h510);
    push_rd(16'h400, 4);
    wr(4'd0, C_SET_EN | C_SET_SUP | C_DIR_RD);
    wait_halt();
    rd(4'd0, v); chk("R4 csr single-update", v, S_SUP | S_RD | S_DONE);
    rd(4'd1, v); chk("R4 no chain taken", v, 32'h410);

    // R9 reset command clears status and the pending chain
    wr(4'd0, C_RESET);
    rd(4'd0, v); chk("R9 csr after reset cmd", v, 32'h0);
    wr(4'd1, 32'h600); wr(4'd2, 32'h610);
    push_rd(16'h600, 4);
    wr(4'd0, C_SET_EN | C_DIR_RD);
    wait_halt();
    rd(4'd1, v); chk("R9 pending chain dropped", v, 32'h610);
    rd(4'd0, v); chk("R9 csr after run", v, S_RD | S_DONE);
    wr(4'd0, C_CLR_DN);

    // R8 bus exception
    wr(4'd1, 32'h700); wr(4'd2, 32'h720);
    err_addr = 16'h708;
    push_rd(16'h700, 2);
    exp_seq++; // word consumed by the faulting access
    wr(4'd0, C_SET_EN | C_DIR_RD);
    wait_halt();
    rd(4'd0, v); chk("R8 csr after fault", v, S_BERR | S_RD);
    rd(4'd1, v); chk("R8 next frozen", v, 32'h708);
    chk("R8 irq on fault", 32'(irq), 32'h1);
    err_addr = 16'hFFFF;
    wr(4'd0, C_SET_EN | C_DIR_RD);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk("R8 no request while faulted", 32'(reqs), 32'h0);
    rd(4'd0, v); chk("R8 fault sticky", v, S_BERR | S_RD | S_EN);
    wr(4'd0, C_RESET);
    // enable was set at that write, so direction keeps its value
    rd(4'd0, v); chk("R9 reset clears fault", v, S_RD);

    // R10 direction ignored while enabled
    wr(4'd1, 32'h800); wr(4'd2, 32'h800);
    wr(4'd0, C_SET_EN);
    wr(4'd0, C_SET_EN | C_DIR_RD);
    rd(4'd0, v); chk("R10 direction held", v, S_EN);
    wr(4'd0, C_RESET);
    rd(4'd0, v); chk("R10 after reset", v, 32'h0);

    // R7 snapshot command
    wr(4'd1, 32'h900); wr(4'd2, 32'h940); wr(4'd3, 32'hA00); wr(4'd4, 32'hA40);
    wr(4'd0, C_SNAP);
    rd(4'd5, v); chk("R7 snap next", v, 32'h900);
    rd(4'd6, v); chk("R7 snap limit", v, 32'h940);
    rd(4'd7, v); chk("R7 snap start", v, 32'hA00);
    rd(4'd8, v); chk("R7 snap stop", v, 32'hA40);
    wr(4'd0, C_RESET);

    chk("R3 final queues empty", 32'(exp_maddr.size() + exp_dev.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule